// File: doc/BRIEF.md
# Hall Tachometer and Rotation Direction Indicator

This block watches the three Hall sensor inputs of a three-phase brushless motor and turns them into two indications: a tacho output and a direction output. The tacho output toggles each time the rotor passes a commutation point, which is defined as a change from one valid Hall code to a different valid Hall code. The direction output shows which way the rotor is actually turning. It is inferred from whether the new code is the next or the previous entry in the six-step Hall sequence. Because it is derived from the sensor order and not from any drive command, the direction output does not flip while a commanded reversal is only braking a spinning rotor.

The Hall lines come from outside the clock domain, so they first pass through a synchroniser. An optional debounce filter follows, which only accepts a code after it has been stable for a set number of cycles. The direction output is only ever rewritten when a commutation is accepted. Codes 000 and 111 are never legal positions, and they are ignored. The filter keeps the last valid code as its reference, so the step after an invalid interval is judged against the position before that interval.

Top module: `hall_tacho_dir`

## Requirements
- R1: After reset, tacho_o is 0 and dir_o is 1, and no reference code is held.
- R2: The forward sequence of Hall codes {hall_i[2],hall_i[1],hall_i[0]} is 101, 100, 110, 010, 011, 001, and then it wraps back to 101. tacho_o toggles at every commutation, in either direction.
- R3: A commutation to the next code of the forward sequence drives dir_o high. A commutation to the previous code, including the wrap from 101 to 001, drives dir_o low.
- R4: dir_o changes only at a commutation. A commutation to a valid code that is not adjacent to the reference code toggles tacho_o and leaves dir_o unchanged.
- R5: Codes 000 and 111 are not commutations. They leave tacho_o, dir_o and the reference code unchanged.
- R6: The first valid code after reset only sets the reference and does not toggle tacho_o. A valid code equal to the reference is not a commutation.
- R7: hall_i passes through SYNC_STAGES flops. When DEBOUNCE_CYCLES is non-zero, a code change that lasts fewer than DEBOUNCE_CYCLES synchronised cycles is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_i | input | 3 | Raw Hall sensor levels, asynchronous |
| tacho_o | output | 1 | Toggles at each accepted commutation |
| dir_o | output | 1 | 1 = forward rotation, 0 = reverse rotation |

## Verification
A toggle of tacho_o and a rewrite of dir_o land on the same clock edge whenever a commutation reverses the observed direction. The vector table provokes this with reversals in the middle of the sequence and at the 101/001 wrap, and it judges both outputs at one sample point after each step. The same table also places non-adjacent jumps and invalid codes next to those reversals. This confirms that only the tacho half of the pair fires in those cases. Directed tests then apply short glitches and a reset in the middle of a run.

// File: rtl/hall_pkg.sv
package hall_pkg;

    typedef logic [2:0] hall_code_t;

    typedef struct packed {
        logic       tacho;
        logic       dir;
        logic       ref_ok;
        hall_code_t ref_code;
    } hall_state_t;

    // Position of a code in the forward six-step order; valid=0 for 000/111.
    typedef struct packed {
        logic       valid;
        logic [2:0] idx;
    } hall_step_t;

    function automatic hall_step_t code_to_step(input hall_code_t c);
        hall_step_t s;
        s.valid = 1'b1;
        unique case (c)
            3'b101:  s.idx = 3'd0;
            3'b100:  s.idx = 3'd1;
            3'b110:  s.idx = 3'd2;
            3'b010:  s.idx = 3'd3;
            3'b011:  s.idx = 3'd4;
            3'b001:  s.idx = 3'd5;
            default: begin
                s.idx   = 3'd0;
                s.valid = 1'b0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= '0;
                else        chain_q[i] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= '0;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hall_debounce.sv
module hall_debounce #(
    parameter int CYCLES = 3,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] filt_o
);
    if (CYCLES == 0) begin : g_bypass
        assign filt_o = raw_i;
    end else begin : g_filter
        localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
        localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

        typedef struct packed {
            logic [W-1:0]  cand;
            logic [W-1:0]  stable;
            logic [CW-1:0] cnt;
        } db_state_t;

        db_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (raw_i != st_q.cand) begin
                st_d.cand = raw_i;
                st_d.cnt  = '0;
            end else if (st_q.cand != st_q.stable) begin
                if (st_q.cnt == LAST) begin
                    st_d.stable = st_q.cand;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign filt_o = st_q.stable;
    end
endmodule

// File: rtl/hall_tacho_dir.sv
module hall_tacho_dir #(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    output logic       tacho_o,
    output logic       dir_o
);
    import hall_pkg::*;

    hall_code_t  sync_code;
    hall_code_t  filt_code;
    hall_step_t  new_step;
    hall_step_t  ref_step;
    hall_state_t st_d, st_q;
    logic        commut;
    logic [2:0]  fwd_idx;
    logic [2:0]  rev_idx;

    hall_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (hall_i),
        .q_o   (sync_code)
    );

    hall_debounce #(.CYCLES(DEBOUNCE_CYCLES), .W(3)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (sync_code),
        .filt_o (filt_code)
    );

    always_comb begin
        new_step = code_to_step(filt_code);
        ref_step = code_to_step(st_q.ref_code);
        fwd_idx  = (ref_step.idx == 3'd5) ? 3'd0 : ref_step.idx + 3'd1;
        rev_idx  = (ref_step.idx == 3'd0) ? 3'd5 : ref_step.idx - 3'd1;
        commut   = new_step.valid && st_q.ref_ok && (filt_code != st_q.ref_code);

        st_d = st_q;
        if (new_step.valid && !st_q.ref_ok) begin
            st_d.ref_ok   = 1'b1;
            st_d.ref_code = filt_code;
        end else if (commut) begin
            st_d.tacho    = ~st_q.tacho;
            st_d.ref_code = filt_code;
            if (new_step.idx == fwd_idx)      st_d.dir = 1'b1;
            else if (new_step.idx == rev_idx) st_d.dir = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tacho    <= 1'b0;
            st_q.dir      <= 1'b1;
            st_q.ref_ok   <= 1'b0;
            st_q.ref_code <= 3'b000;
        end else begin
            st_q <= st_d;
        end
    end

    assign tacho_o = st_q.tacho;
    assign dir_o   = st_q.dir;
endmodule

// File: rtl/hall_tacho_dir_chk.sv
module hall_tacho_dir_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] filt_code,
    input logic [2:0] ref_code,
    input logic       ref_ok,
    input logic       tacho_o,
    input logic       dir_o
);
    logic       bad_code;
    logic       step_seen;
    logic [2:0] succ;
    logic [2:0] pred;

    always_comb begin
        case (ref_code)
            3'b101:  begin succ = 3'b100; pred = 3'b001; end
            3'b100:  begin succ = 3'b110; pred = 3'b101; end
            3'b110:  begin succ = 3'b010; pred = 3'b100; end
            3'b010:  begin succ = 3'b011; pred = 3'b110; end
            3'b011:  begin succ = 3'b001; pred = 3'b010; end
            default: begin succ = 3'b101; pred = 3'b011; end
        endcase
        bad_code  = (filt_code == 3'b000) || (filt_code == 3'b111);
        step_seen = ref_ok && !bad_code && (filt_code != ref_code);
    end

    AST_TACHO_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tacho_o) |-> $past(step_seen)); // R2
    AST_FWD_DIR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_seen && filt_code == succ) |=> dir_o); // R3
    AST_REV_DIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (step_seen && filt_code == pred) |=> !dir_o); // R3
    AST_DIR_ONLY_AT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_o) |-> $past(step_seen)); // R4
    AST_STEP_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        step_seen |=> !$stable(tacho_o)); // R2
    AST_BAD_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_code |=> ($stable(tacho_o) && $stable(dir_o) && $stable(ref_code))); // R5
    AST_FIRST_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_ok |=> $stable(tacho_o)); // R6
endmodule

bind hall_tacho_dir hall_tacho_dir_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .filt_code (filt_code),
    .ref_code  (st_q.ref_code),
    .ref_ok    (st_q.ref_ok),
    .tacho_o   (tacho_o),
    .dir_o     (dir_o)
);

// File: tb/hall_tacho_dir_test.sv
module hall_tacho_dir_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_i = 3'b000;
    logic       tacho_o, dir_o;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    localparam int SETTLE = 12;

    always #4 clk = ~clk;

    hall_tacho_dir uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .hall_i  (hall_i),
        .tacho_o (tacho_o),
        .dir_o   (dir_o)
    );

    // {code, expected tacho, expected dir}
    localparam int NV = 19;
    localparam logic [4:0] VEC [NV] = '{
        {3'b101, 1'b0, 1'b1},  // R6 first valid: reference only
        {3'b100, 1'b1, 1'b1},  // R2 R3 forward
        {3'b110, 1'b0, 1'b1},
        {3'b010, 1'b1, 1'b1},
        {3'b110, 1'b0, 1'b0},  // R3 reversal
        {3'b100, 1'b1, 1'b0},
        {3'b101, 1'b0, 1'b0},
        {3'b001, 1'b1, 1'b0},  // R3 reverse wrap
        {3'b101, 1'b0, 1'b1},  // R3 forward wrap
        {3'b111, 1'b0, 1'b1},  // R5 invalid
        {3'b100, 1'b1, 1'b1},  // R5 judged against last valid
        {3'b000, 1'b1, 1'b1},  // R5 invalid
        {3'b100, 1'b1, 1'b1},  // R6 same as reference
        {3'b001, 1'b0, 1'b1},  // R4 non-adjacent
        {3'b010, 1'b1, 1'b1},  // R4 non-adjacent
        {3'b011, 1'b0, 1'b1},
        {3'b001, 1'b1, 1'b1},
        {3'b011, 1'b0, 1'b0},
        {3'b100, 1'b1, 1'b0}   // R4 opposite code
    };

    task automatic check(input string req, input logic exp_t, input logic exp_d);
        n_chk++;
        if (tacho_o !== exp_t || dir_o !== exp_d) begin
            n_bad++;
            $display("FAIL %s: tacho/dir actual %b/%b expected %b/%b",
                     req, tacho_o, dir_o, exp_t, exp_d);
        end
    endtask

    task automatic hold(input logic [2:0] c, input int cyc);
        hall_i = c;
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            hold(VEC[i][4:2], SETTLE);
            check($sformatf("R2-R6 vector %0d", i), VEC[i][1], VEC[i][0]);
        end

        // R7: glitches shorter than the debounce window are discarded
        hold(3'b110, 1);
        hold(3'b100, SETTLE);
        check("R7 one-cycle glitch", 1'b1, 1'b0);
        hold(3'b110, 2);
        hold(3'b100, SETTLE);
        check("R7 two-cycle glitch", 1'b1, 1'b0);
        hold(3'b110, SETTLE);
        check("R7 held change accepted", 1'b0, 1'b1);

        // R1 R6: reset mid-run, then first valid code only sets reference
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", 1'b0, 1'b1);
        rst_n = 1'b1;
        hold(3'b010, SETTLE);
        check("R6 first code after reset", 1'b0, 1'b1);
        hold(3'b110, SETTLE);
        check("R3 reverse after reset", 1'b1, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(negedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule